// File: doc/BRIEF.md
# Infrared Controller Event Status Registers

This block holds the event and condition status of an infrared serial controller and makes it readable over a simple 32-bit register port. Single-cycle event pulses from the datapath set sticky bits. A sticky bit stays set until software writes a one to its position. Level conditions from the datapath appear as read-only flags that follow their inputs directly. Both registers are 8 bits wide and sit in the low byte of their own 32-bit word. All other bits read as zero.

One registered interrupt line is driven from the sticky bits. Each bit can be masked, except the end/error bit, which always interrupts. The end/error bit is set whenever the receive buffer's output entry carries any of its five tag bits. While that bit is set, the receive-side DMA request is held low, so that software can inspect the frame boundary first. The register port is a control path with no flow control: a write takes effect at the next clock edge, and a read returns data in the same cycle.

Top module: `irstat_regs`

## Requirements
- R1: The event register is at byte offset 0x0 and the flag register is at offset 0x4. Both are selected by address bits [3:2], and address bits [1:0] are ignored. Bits 31:8 of every read are zero, and any other offset reads as all zeros.
- R2: The event register bits are: bit0 transmit underrun, bit1 receive abort, bit2 framing error, bit3 end/error, bit4 CRC error, bit5 overrun. Bits 7:6 are zero. An event pulse present at a clock edge sets its bit, and the bit stays set until it is cleared.
- R3: A write to offset 0x0 clears every event bit whose write-data bit is 1, at the next edge. Bits written with 0 are unchanged. A write to offset 0x4 changes no event bit.
- R4: Flag register bits are: bit0 transmitter busy, bit1 receiver synchronized, bit2 receive buffer not empty, bit3 transmit buffer not full. Reads show the flag inputs in the same cycle, and writes have no effect on them.
- R5: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq_o` is registered. It is high in the cycle after any enabled event bit is set, and low in the cycle after none is.
- R7: `irq_mask_i[i]=1` removes event bit i from the interrupt. `irq_mask_i[3]` has no effect, because the end/error bit always interrupts.
- R8: The end/error bit is set at every edge where any bit of `rx_tag_i` is 1. A clear while a tag is still present leaves it set.
- R9: `rx_dma_req_o` equals `rx_dma_want_i` while the end/error bit is clear, and is 0 while it is set.
- R10: The flag inputs never cause an interrupt.
- R11: After reset all event bits are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| ev_underrun_i | input | 1 | Transmit underrun event pulse |
| ev_abort_i | input | 1 | Receive abort event pulse |
| ev_frame_i | input | 1 | Framing error event pulse |
| ev_crc_i | input | 1 | CRC error event pulse |
| ev_overrun_i | input | 1 | Receive overrun event pulse |
| rx_tag_i | input | TAG_W | Tag bits of the receive buffer output entry |
| flag_i | input | 4 | Live condition flags (see R4) |
| irq_mask_i | input | 6 | Per-bit interrupt mask, 1 = masked |
| rx_dma_want_i | input | 1 | Receive buffer asks for DMA service |
| irq_o | output | 1 | Registered interrupt request |
| rx_dma_req_o | output | 1 | Gated receive DMA request |

## Verification
The bench's first target is the collision between a hardware event and a software clear on the same bit. A design that lets the clear win drops an event and reads back zero. A design that clears on written zeros wipes unrelated bits. The end/error bit gets its own cases: a clear attempted while a tag is still present, a set mask bit that must not silence it, and the DMA gate. A wrong design either lets a DMA request through after a tagged entry or keeps it blocked once the bit is cleared. The bench also covers the one-cycle interrupt lag, writes to the flag word that must not disturb the event bits, and unmapped offsets. A design that decodes too few address bits would alias those offsets onto live registers.

// File: rtl/irstat_pkg.sv
package irstat_pkg;
  localparam int REG_W  = 8;
  localparam int ST_W   = 6;
  localparam int FLAG_W = 4;
  localparam int TAG_DEF_W = 5;

  localparam int B_TUR = 0;
  localparam int B_ABT = 1;
  localparam int B_FRM = 2;
  localparam int B_EOE = 3;
  localparam int B_CRC = 4;
  localparam int B_OVR = 5;

  localparam logic [ST_W-1:0] NONMASK_BITS = ST_W'(1) << B_EOE;

  typedef logic [ST_W-1:0]   st_vec_t;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/irstat_sticky_bank.sv
module irstat_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    // Set has priority over clear so an event is never lost.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_i[g])   q <= 1'b1;
      else if (clr_i[g])   q <= 1'b0;
    end
    assign q_o[g] = q;

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[g] && !clr_i[g]) |=> q_o[g]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && set_i[g]) |=> q_o[g]);
  end
endmodule

// File: rtl/irstat_irq_gen.sv
module irstat_irq_gen #(
  parameter int           N        = 6,
  parameter logic [N-1:0] FIXED_EN = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  logic         irq_q;

  assign live = status_i & (~mask_i | FIXED_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
  assign irq_o = irq_q;

  assert_fixed_bits_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & FIXED_EN)) |=> irq_o);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> !irq_o);
endmodule

// File: rtl/irstat_rd_mux.sv
module irstat_rd_mux #(
  parameter int WORD_W = 2,
  parameter int DATA_W = 32,
  parameter int ST_W   = 6,
  parameter int FLAG_W = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (word_i == WORD_W'(0))      rdata_o[ST_W-1:0]   = status_i;
    else if (word_i == WORD_W'(1)) rdata_o[FLAG_W-1:0] = flag_i;
  end
endmodule

// File: rtl/irstat_regs.sv
module irstat_regs
  import irstat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = TAG_DEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ev_underrun_i,
  input  logic              ev_abort_i,
  input  logic              ev_frame_i,
  input  logic              ev_crc_i,
  input  logic              ev_overrun_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [ST_W-1:0]   irq_mask_i,
  input  logic              rx_dma_want_i,
  output logic              irq_o,
  output logic              rx_dma_req_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  st_vec_t           set_v;
  st_vec_t           clr_v;
  st_vec_t           status;
  logic              unused_bits;

  assign word_idx    = bus_addr_i[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[DATA_W-1:ST_W]};

  always_comb begin
    set_v        = '0;
    set_v[B_TUR] = ev_underrun_i;
    set_v[B_ABT] = ev_abort_i;
    set_v[B_FRM] = ev_frame_i;
    set_v[B_EOE] = |rx_tag_i;
    set_v[B_CRC] = ev_crc_i;
    set_v[B_OVR] = ev_overrun_i;
  end

  assign clr_v = (bus_sel_i && bus_wr_i && word_idx == WORD_W'(0))
               ? bus_wdata_i[ST_W-1:0] : '0;

  irstat_sticky_bank #(.N(ST_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (status)
  );

  irstat_irq_gen #(.N(ST_W), .FIXED_EN(NONMASK_BITS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .mask_i   (irq_mask_i),
    .irq_o    (irq_o)
  );

  irstat_rd_mux #(.WORD_W(WORD_W), .DATA_W(DATA_W), .ST_W(ST_W), .FLAG_W(FLAG_W)) u_rd (
    .word_i   (word_idx),
    .status_i (status),
    .flag_i   (flag_i),
    .rdata_o  (bus_rdata_o)
  );

  assign rx_dma_req_o = rx_dma_want_i & ~status[B_EOE];

  assert_tag_sets_eoe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_tag_i) |=> status[B_EOE]);
  assert_tag_blocks_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_tag_i) |=> !rx_dma_req_o);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:REG_W] == '0);
endmodule

// File: tb/irstat_regs_test.sv
`timescale 1ns/1ps
module irstat_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        ev_tur, ev_abt, ev_frm, ev_crc, ev_ovr;
  logic [4:0]  tag;
  logic [3:0]  flags;
  logic [5:0]  mask;
  logic        want, irq, dma;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [5:0] m_st;
  logic       m_irq;

  always #2.5 clk = ~clk;

  irstat_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ev_underrun_i(ev_tur),
    .ev_abort_i(ev_abt), .ev_frame_i(ev_frm), .ev_crc_i(ev_crc),
    .ev_overrun_i(ev_ovr), .rx_tag_i(tag), .flag_i(flags), .irq_mask_i(mask),
    .rx_dma_want_i(want), .irq_o(irq), .rx_dma_req_o(dma)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin : model
    logic [5:0] s, c;
    if (!rst_n) begin
      m_st  <= '0;
      m_irq <= 1'b0;
    end else begin
      s = {ev_ovr, ev_crc, (tag != 0), ev_frm, ev_abt, ev_tur};
      c = (sel && wr && addr[3:2] == 2'd0) ? wdata[5:0] : 6'd0;
      m_irq <= |(m_st & (~mask | 6'b001000));
      m_st  <= (m_st & ~c) | s;
    end
  end

  function automatic logic [31:0] exp_rd();
    case (addr[3:2])
      2'd0:    return {26'd0, m_st};
      2'd1:    return {28'd0, flags};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag_s, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(addr[3:2] == 2'd1 ? "R4" : "R2", rdata, exp_rd());
      chk("R6", {31'd0, irq}, {31'd0, m_irq});
      chk("R9", {31'd0, dma}, {31'd0, want & ~m_st[3]});
    end
  end

  task automatic step();
    @(posedge clk); #1;
    ev_tur = 0; ev_abt = 0; ev_frm = 0; ev_crc = 0; ev_ovr = 0;
    sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic probe();
    @(negedge clk); #0.5;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
    ev_tur = 0; ev_abt = 0; ev_frm = 0; ev_crc = 0; ev_ovr = 0;
    tag = 0; flags = 0; mask = 0; want = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    probe();
    chk("R11", rdata, 32'h0);
    chk("R11", {31'd0, irq}, 32'h0);

    // R2 / R6: event sets sticky bit, interrupt one cycle later
    ev_tur = 1; step(); probe();
    chk("R2", rdata, 32'h01);
    chk("R6", {31'd0, irq}, 32'h0);
    step(); probe();
    chk("R6", {31'd0, irq}, 32'h1);
    step(); step(); probe();
    chk("R2", rdata, 32'h01);

    // R3: write zero keeps, write one clears
    wr_reg(4'h0, 32'h0); step(); probe();
    chk("R3", rdata, 32'h01);
    wr_reg(4'h0, 32'h1); step(); probe();
    chk("R3", rdata, 32'h00);
    chk("R6", {31'd0, irq}, 32'h1);
    step(); probe();
    chk("R6", {31'd0, irq}, 32'h0);

    // R5: simultaneous set and clear
    ev_abt = 1; wr_reg(4'h0, 32'h2); step(); probe();
    chk("R5", rdata, 32'h02);
    wr_reg(4'h0, 32'h2); step(); probe();
    chk("R5", rdata, 32'h00);

    // R7: maskable bit
    mask = 6'b000010; ev_abt = 1; step(); step(); step(); probe();
    chk("R7", {31'd0, irq}, 32'h0);
    chk("R7", rdata, 32'h02);
    mask = 0; step(); probe();
    chk("R7", {31'd0, irq}, 32'h1);
    wr_reg(4'h0, 32'h2); step(); step(); probe();
    chk("R7", {31'd0, irq}, 32'h0);

    // R8 / R9: tag sets end/error, blocks DMA, non-maskable
    want = 1; probe();
    chk("R9", {31'd0, dma}, 32'h1);
    tag = 5'b10000; step(); probe();
    chk("R8", rdata, 32'h08);
    chk("R9", {31'd0, dma}, 32'h0);
    mask = 6'h3F; step(); probe();
    chk("R7", {31'd0, irq}, 32'h1);
    wr_reg(4'h0, 32'h8); step(); probe();
    chk("R8", rdata, 32'h08);
    tag = 0; wr_reg(4'h0, 32'h8); step(); probe();
    chk("R8", rdata, 32'h00);
    chk("R9", {31'd0, dma}, 32'h1);
    mask = 0; tag = 5'b00001; step(); probe();
    chk("R8", rdata, 32'h08);
    chk("R9", {31'd0, dma}, 32'h0);
    tag = 0; wr_reg(4'h0, 32'h8); step(); step(); probe();
    chk("R8", rdata, 32'h00);

    // R4 / R10: flags are live, read-only, never interrupt
    addr = 4'h4; flags = 4'b1010; probe();
    chk("R4", rdata, 32'hA);
    flags = 4'b0101; probe();
    chk("R4", rdata, 32'h5);
    repeat (4) step();
    probe();
    chk("R10", {31'd0, irq}, 32'h0);
    ev_crc = 1; step();
    wr_reg(4'h4, 32'hFF); step(); probe();
    chk("R4", rdata, 32'h5);
    addr = 4'h0; probe();
    chk("R3", rdata, 32'h10);
    wr_reg(4'h0, 32'h10); step();

    // R1: unmapped offset and upper bits
    ev_tur = 1; ev_abt = 1; ev_frm = 1; ev_crc = 1; ev_ovr = 1; tag = 5'b00100;
    step(); tag = 0; addr = 4'h8; probe();
    chk("R1", rdata, 32'h0);
    addr = 4'h3; probe();
    chk("R1", rdata, 32'h3F);
    addr = 4'hC; probe();
    chk("R1", rdata, 32'h0);
    wr_reg(4'h1, 32'hFFFF_FF3F); step(); probe();
    chk("R3", rdata, 32'h0);

    // Random traffic compared against the model every cycle
    for (int i = 0; i < 600; i++) begin
      ev_tur = ($urandom % 8) == 0;
      ev_abt = ($urandom % 8) == 0;
      ev_frm = ($urandom % 8) == 0;
      ev_crc = ($urandom % 8) == 0;
      ev_ovr = ($urandom % 8) == 0;
      tag    = (($urandom % 10) == 0) ? 5'($urandom) : 5'd0;
      flags  = 4'($urandom);
      mask   = 6'($urandom);
      want   = 1'($urandom);
      sel    = 1'($urandom);
      wr     = 1'($urandom);
      addr   = 4'($urandom);
      wdata  = $urandom;
      @(posedge clk); #1;
    end
    step(); probe();
    done = 1;
    summary();
  end
endmodule